// File: doc/BRIEF.md
# I2S Stereo Receiver with 24-bit Word Normalisation

This block takes a stereo serial audio stream in I2S format (bit clock, left/right clock and serial data) and turns it into parallel samples for a datapath that always works on 24-bit signed two's complement values. The three serial lines are oversampled by the block's own system clock, so the bit clock may be any rate well below it. A 2-bit word-length selector sets how many bits of each half-frame are kept. Shorter words are zero-padded at the bottom and 32-bit words lose their lowest eight bits, so downstream logic sees one fixed format.

Each half-frame produces one sample, given with a single-cycle valid strobe and a flag that tells left from right. Separately, the block measures the number of bit clocks in every full left/right period. When a period holds exactly 32 bit clocks, split 16 and 16, the following frame is captured as 16-bit data whatever the selector says. A frame of any other length brings back the selected word length for the frame that follows it.

Top module: `i2s_rx_wlnorm`

## Requirements
- R1: After reset the valid strobe and sample are zero, and no sample comes out until a full half-frame, bounded by two left/right clock transitions, has been received.
- R2: The selector encoding is 2'b00 = 16 bits, 2'b01 = 20 bits, 2'b10 = 24 bits, 2'b11 = 32 bits, and the data is two's complement with its MSB at output bit 23.
- R3: The MSB of a word is sampled on the second rising bit-clock edge after a left/right transition. The last bit slot of a half-frame is the first rising edge after the next transition.
- R4: Each half-frame ends with exactly one valid pulse, one system clock long. Its channel flag is 0 for a half-frame with the left/right clock low (left) and 1 for high (right).
- R5: In 16-bit and 20-bit modes the received word sits in the top bits of the 24-bit sample and the lower 8 or 4 bits are zero.
- R6: In 32-bit mode the sample is the first 24 received bits and the last 8 bits of the word are dropped.
- R7: In 24-bit mode a half-frame of at least 24 bit clocks yields all 24 received bits unchanged.
- R8: Bits that arrive after the selected word length within a half-frame have no effect on the sample.
- R9: A half-frame shorter than the word length gives the bits received, MSB-aligned, with every lower bit zero.
- R10: After a full frame of exactly 32 bit clocks (16 low, 16 high), the next frame is captured with a 16-bit word length, whatever the selector holds.
- R11: After a frame whose length is not 32, the next frame is captured with the selected word length again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Serial bit clock |
| lrclk_i | input | 1 | Left/right clock, low for left |
| sdata_i | input | 1 | Serial data, MSB first |
| wl_sel_i | input | 2 | Word-length selector (R2 encoding) |
| smp_o | output | 24 | Normalised signed sample |
| smp_vld_o | output | 1 | One-cycle strobe, sample valid |
| smp_right_o | output | 1 | Channel of the sample: 0 left, 1 right |

## Verification
The 16-bit auto-detect is the hardest behaviour to see from the ports. A 32-clock frame gives the same 16-bit result under any selector, so the switch cannot be seen in the frame that triggers it. The stimulus therefore puts long 64-clock frames and 48-clock frames right after a run of 32-clock frames. There the forced 16-bit truncation changes the sample, and the frame after that shows the return to the selected length. The same frame sequence runs under each of the four selector codes, with a reset before each code.

// File: rtl/i2srx_pkg.sv
package i2srx_pkg;

   typedef enum logic [1:0] {
      WL_16 = 2'b00,
      WL_20 = 2'b01,
      WL_24 = 2'b10,
      WL_32 = 2'b11
   } wl_code_e;

   // number of bits kept for a given selector code
   function automatic int unsigned wl_bits(input wl_code_e code);
      case (code)
         WL_16:   return 16;
         WL_20:   return 20;
         WL_24:   return 24;
         default: return 32;
      endcase
   endfunction

   // bit clocks per half-frame that mark a 16-bit frame
   localparam int unsigned AUTO_HALF = 16;

endpackage

// File: rtl/i2srx_insync.sv
module i2srx_insync #(
   parameter int unsigned STAGES     = 2,
   parameter bit          REG_STROBE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_i,
   input  logic lrclk_i,
   input  logic sdata_i,
   output logic rise_o,
   output logic lr_o,
   output logic bit_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2srx_insync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] bclk_q, lr_q, dat_q;
   logic              bclk_last;
   logic              rise_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_q    <= '0;
         lr_q      <= '0;
         dat_q     <= '0;
         bclk_last <= 1'b0;
      end else begin
         bclk_q    <= {bclk_q[STAGES-2:0], bclk_i};
         lr_q      <= {lr_q[STAGES-2:0], lrclk_i};
         dat_q     <= {dat_q[STAGES-2:0], sdata_i};
         bclk_last <= bclk_q[STAGES-1];
      end
   end

   assign rise_c = bclk_q[STAGES-1] & ~bclk_last;

   if (REG_STROBE) begin : g_reg_strobe
      logic rise_r, lr_r, bit_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rise_r <= 1'b0;
            lr_r   <= 1'b0;
            bit_r  <= 1'b0;
         end else begin
            rise_r <= rise_c;
            lr_r   <= lr_q[STAGES-1];
            bit_r  <= dat_q[STAGES-1];
         end
      end
      assign rise_o = rise_r;
      assign lr_o   = lr_r;
      assign bit_o  = bit_r;
   end else begin : g_comb_strobe
      assign rise_o = rise_c;
      assign lr_o   = lr_q[STAGES-1];
      assign bit_o  = dat_q[STAGES-1];
   end

   AST_RISE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o); // R3

endmodule

// File: rtl/i2srx_framer.sv
module i2srx_framer
   import i2srx_pkg::*;
#(
   parameter int unsigned HCNT_W = 8,
   parameter int unsigned LIM_W  = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise_i,
   input  logic             lr_i,
   input  logic [1:0]       wl_sel_i,
   output logic             xfer_o,
   output logic             emit_o,
   output logic             chan_o,
   output logic [LIM_W-1:0] lim_o
);

   if (HCNT_W < 6) begin : g_bad_hcnt
      $error("i2srx_framer: HCNT_W too small to measure a 16-clock half");
   end

   localparam logic [HCNT_W-1:0] HALF16 = HCNT_W'(AUTO_HALF);
   localparam logic [HCNT_W-1:0] HMAX   = '1;

   logic              have_lr, lr_q, armed;
   logic [HCNT_W-1:0] hcnt_q, left_len_q;
   logic              left_ok_q, auto16_q;

   assign xfer_o = rise_i && have_lr && (lr_i != lr_q);
   assign emit_o = xfer_o && armed;
   assign chan_o = lr_q;
   assign lim_o  = auto16_q ? LIM_W'(AUTO_HALF) : LIM_W'(wl_bits(wl_code_e'(wl_sel_i)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_lr    <= 1'b0;
         lr_q       <= 1'b0;
         armed      <= 1'b0;
         hcnt_q     <= '0;
         left_len_q <= '0;
         left_ok_q  <= 1'b0;
         auto16_q   <= 1'b0;
      end else if (rise_i) begin
         have_lr <= 1'b1;
         lr_q    <= lr_i;
         if (xfer_o) begin
            armed  <= 1'b1;
            hcnt_q <= HCNT_W'(1);
            if (lr_i) begin
               // left half just closed
               left_len_q <= hcnt_q;
               left_ok_q  <= armed;
            end else begin
               // full frame closed: decide the capture mode of the next one
               auto16_q <= armed && left_ok_q && (left_len_q == HALF16) && (hcnt_q == HALF16);
            end
         end else if (hcnt_q != HMAX) begin
            hcnt_q <= hcnt_q + HCNT_W'(1);
         end
      end
   end

   AST_AUTO_AT_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(auto16_q) |-> $past(xfer_o && !lr_i)); // R10

   AST_CHAN_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_o |=> (lr_q != $past(lr_q))); // R4

   AST_NO_EARLY_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_o && !armed) |=> armed); // R1

endmodule

// File: rtl/i2srx_capture.sv
module i2srx_capture #(
   parameter int unsigned MAX_W = 32,
   parameter int unsigned OUT_W = 24,
   parameter int unsigned LIM_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise_i,
   input  logic             bit_i,
   input  logic             xfer_i,
   input  logic             emit_i,
   input  logic             chan_i,
   input  logic [LIM_W-1:0] lim_i,
   output logic [OUT_W-1:0] smp_o,
   output logic             vld_o,
   output logic             right_o
);

   if (OUT_W <= 20 || OUT_W > MAX_W) begin : g_bad_out
      $error("i2srx_capture: OUT_W must lie in (20, MAX_W]");
   end

   logic [MAX_W-1:0] acc_q, acc_nx;
   logic [LIM_W-1:0] cnt_q;
   logic             room;

   assign room = (cnt_q < lim_i);

   // decoded write: each bit lands at its final MSB-aligned position
   always_comb begin
      acc_nx = acc_q;
      for (int i = 0; i < MAX_W; i++) begin
         if (room && (cnt_q == LIM_W'(i))) acc_nx[MAX_W-1-i] = bit_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         cnt_q   <= '0;
         smp_o   <= '0;
         vld_o   <= 1'b0;
         right_o <= 1'b0;
      end else begin
         vld_o <= 1'b0;
         if (rise_i) begin
            if (xfer_i) begin
               acc_q <= '0;
               cnt_q <= '0;
               if (emit_i) begin
                  smp_o   <= acc_nx[MAX_W-1 -: OUT_W];
                  vld_o   <= 1'b1;
                  right_o <= chan_i;
               end
            end else begin
               acc_q <= acc_nx;
               if (room) cnt_q <= cnt_q + LIM_W'(1);
            end
         end
      end
   end

   AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |=> !vld_o); // R4

   AST_PAD_16: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_i && emit_i && lim_i == LIM_W'(16)) |=> (smp_o[OUT_W-17:0] == '0)); // R5

   AST_PAD_20: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_i && emit_i && lim_i == LIM_W'(20)) |=> (smp_o[OUT_W-21:0] == '0)); // R5

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LIM_W'(MAX_W)); // R8

   AST_CLEAR_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_i && xfer_i) |=> (cnt_q == '0)); // R3

endmodule

// File: rtl/i2s_rx_wlnorm.sv
module i2s_rx_wlnorm #(
   parameter int unsigned MAX_W       = 32,
   parameter int unsigned OUT_W       = 24,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          REG_STROBE  = 1'b0,
   parameter int unsigned HCNT_W      = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bclk_i,
   input  logic             lrclk_i,
   input  logic             sdata_i,
   input  logic [1:0]       wl_sel_i,
   output logic [OUT_W-1:0] smp_o,
   output logic             smp_vld_o,
   output logic             smp_right_o
);

   localparam int unsigned LIM_W = $clog2(MAX_W + 1);

   if (MAX_W < 32) begin : g_bad_max
      $error("i2s_rx_wlnorm: MAX_W must hold a 32-bit word");
   end

   logic             rise_w, lr_w, bit_w;
   logic             xfer_w, emit_w, chan_w;
   logic [LIM_W-1:0] lim_w;

   i2srx_insync #(
      .STAGES     (SYNC_STAGES),
      .REG_STROBE (REG_STROBE)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .bclk_i  (bclk_i),
      .lrclk_i (lrclk_i),
      .sdata_i (sdata_i),
      .rise_o  (rise_w),
      .lr_o    (lr_w),
      .bit_o   (bit_w)
   );

   i2srx_framer #(
      .HCNT_W (HCNT_W),
      .LIM_W  (LIM_W)
   ) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise_i   (rise_w),
      .lr_i     (lr_w),
      .wl_sel_i (wl_sel_i),
      .xfer_o   (xfer_w),
      .emit_o   (emit_w),
      .chan_o   (chan_w),
      .lim_o    (lim_w)
   );

   i2srx_capture #(
      .MAX_W (MAX_W),
      .OUT_W (OUT_W),
      .LIM_W (LIM_W)
   ) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise_i  (rise_w),
      .bit_i   (bit_w),
      .xfer_i  (xfer_w),
      .emit_i  (emit_w),
      .chan_i  (chan_w),
      .lim_i   (lim_w),
      .smp_o   (smp_o),
      .vld_o   (smp_vld_o),
      .right_o (smp_right_o)
   );

   AST_VLD_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      smp_vld_o |-> $past(rise_w && xfer_w)); // R4

endmodule

// File: tb/sim_i2s_rx_wlnorm.sv
`timescale 1ns/1ps
module sim_i2s_rx_wlnorm;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bclk, lrclk, sdata;
   logic [1:0]  wl_sel;
   logic [23:0] smp;
   logic        vld, right;

   always #2.5 clk = ~clk;

   i2s_rx_wlnorm u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .bclk_i      (bclk),
      .lrclk_i     (lrclk),
      .sdata_i     (sdata),
      .wl_sel_i    (wl_sel),
      .smp_o       (smp),
      .smp_vld_o   (vld),
      .smp_right_o (right)
   );

   typedef struct {
      logic [23:0] d;
      logic        ch;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   total = 0;
   int   bad   = 0;
   bit   auto_m, prev_auto;
   int   wlb;
   logic tail;
   logic vld_prev = 1'b0;

   // ---------------- monitor ----------------
   always @(negedge clk) begin
      if (rst_n && vld) begin
         total++;
         if (q.size() == 0) begin
            bad++;
            $display("FAIL R1: sample %h ch %0b produced, expected none", smp, right);
         end else begin
            exp_t e;
            e = q.pop_front();
            if (smp !== e.d || right !== e.ch) begin
               bad++;
               $display("FAIL %s: got %h ch %0b, expected %h ch %0b", e.tag, smp, right, e.d, e.ch);
            end
         end
         if (vld_prev) begin
            total++; bad++;
            $display("FAIL R4: valid high %0d cycles, expected 1", 2);
         end
      end
      vld_prev <= rst_n && vld;
   end

   // ---------------- driver ----------------
   task automatic bclk_cycle(input logic lr, input logic d);
      repeat (4) @(posedge clk);
      #1; bclk = 1'b0; lrclk = lr; sdata = d;
      repeat (4) @(posedge clk);
      #1; bclk = 1'b1;
   endtask

   task automatic send_half(input logic ch, input int len, input logic [31:0] w,
                            input bit expect_out, input int m, input string tg);
      for (int j = 0; j < len; j++)
         bclk_cycle(ch, (j == 0) ? tail : w[31-(j-1)]);
      tail = w[31-(len-1)];
      if (expect_out) begin
         exp_t e;
         logic [31:0] e32;
         int n;
         n   = (len < m) ? len : m;
         e32 = '0;
         for (int i = 0; i < n; i++) e32[31-i] = w[31-i];
         e.d = e32[31:8]; e.ch = ch; e.tag = tg;
         q.push_back(e);
      end
   endtask

   task automatic send_frame(input int flen);
      int    h, m;
      string tg;
      h  = flen / 2;
      m  = auto_m ? 16 : wlb;
      tg = "R2 R3 R4";
      if (auto_m)         tg = {tg, " R10"};
      else if (prev_auto) tg = {tg, " R11"};
      if (h < m)          tg = {tg, " R9"};
      else if (h > m)     tg = {tg, " R8"};
      case (m)
         16, 20:  tg = {tg, " R5"};
         24:      tg = {tg, " R7"};
         default: tg = {tg, " R6"};
      endcase
      send_half(1'b0, h, $urandom(), 1'b1, m, tg);
      send_half(1'b1, h, $urandom(), 1'b1, m, tg);
      prev_auto = auto_m;
      auto_m    = (h == 16);
   endtask

   task automatic run_group(input logic [1:0] code);
      int frames[11] = '{48, 32, 32, 64, 64, 40, 32, 32, 32, 48, 64};
      rst_n = 1'b0; bclk = 1'b0; lrclk = 1'b1; sdata = 1'b0; wl_sel = code;
      case (code)
         2'b00:   wlb = 16;
         2'b01:   wlb = 20;
         2'b10:   wlb = 24;
         default: wlb = 32;
      endcase
      repeat (10) @(posedge clk);
      @(negedge clk);
      total++;
      if (vld !== 1'b0 || smp !== 24'h0) begin
         bad++;
         $display("FAIL R1: reset state vld %0b smp %h, expected 0 000000", vld, smp);
      end
      #1 rst_n = 1'b1;
      auto_m = 0; prev_auto = 0; tail = 1'b0;
      // partial right half before the first transition: no output expected
      send_half(1'b1, 5, $urandom(), 1'b0, 0, "R1");
      foreach (frames[k]) send_frame(frames[k]);
      // trailing partial left half closes the last right half
      send_half(1'b0, 10, $urandom(), 1'b0, 0, "R1");
      repeat (40) @(posedge clk);
      total++;
      if (q.size() != 0) begin
         bad++;
         $display("FAIL R4: %0d samples missing, expected 0", q.size());
         q.delete();
      end
   endtask

   initial begin
      run_group(2'b10);
      run_group(2'b00);
      run_group(2'b01);
      run_group(2'b11);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL R1: watchdog expired, expected run to finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule